// File: doc/BRIEF.md
# Lock Contention Limiter Detector

This block watches lock traffic from a group of hardware threads and names the thread most likely to be on the critical path. Throughout an interval, it adds up how many cycles threads spend blocked on each tracked lock. It also records which thread currently owns each lock. When the interval ends, it finds the lock that collected the most blocked cycles and reports the owner of that lock as the limiter thread. A downstream memory scheduler reads the limiter ID and its valid flag and uses them to raise the priority of that thread's requests.

Every input is a valid-only event or a plain level, and none of them has a ready. Wait indications and acquire/release events are accepted on every cycle, so the block never applies back-pressure. The interval tick is the one exception: a tick that arrives while the search is still running is dropped on purpose. The limiter output is a status pair, not a stream. It holds its value until the next search finishes.

Internally there are three parts: a bank of saturating wait counters, a table of lock owners, and a search engine. On an accepted tick the engine snapshots the counters and the owner table, then compares one lock per cycle.

Top module: `contention_limiter`

## Requirements
- R1: After reset, `limiter_vld` is 0 and `limiter_tid` is 0.
- R2: In each cycle, every thread `t` with `wait_vld[t]` high adds one to the counter of the lock given in `wait_lock[t*LOCK_W +: LOCK_W]`. Several threads blocked on the same lock in the same cycle each add one.
- R3: Each wait counter saturates at 2^CNT_W-1 and stays there until it is cleared.
- R4: On an accepted tick, the lock with the largest snapshot count is selected. If counts are equal, the lower lock index wins.
- R5: If the selected lock has an owner, `limiter_vld` becomes 1 and `limiter_tid` shows the owner as it was recorded at the tick edge.
- R6: If the selected lock has no owner at the tick edge, `limiter_vld` becomes 0 and `limiter_tid` becomes 0.
- R7: If every snapshot count is zero, `limiter_vld` becomes 0 and `limiter_tid` becomes 0.
- R8: A new result is registered on the NUM_LOCKS-1'th rising edge after the edge that accepts the tick. The outputs do not change at any other time.
- R9: A tick that arrives during those NUM_LOCKS-1 search cycles is ignored. It does not restart the search and does not clear any counter.
- R10: An accepted tick clears every counter. Waits sampled in the same cycle as the tick are counted in the new interval.
- R11: `acq_vld` records `acq_tid` as the owner of `acq_lock`, replacing any previous owner. `rel_vld` removes the owner of `rel_lock`. If an acquire and a release name the same lock in the same cycle, the acquire wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_vld | input | NUM_THREADS | Per-thread flag: this thread is blocked this cycle |
| wait_lock | input | NUM_THREADS*LOCK_W | Per-thread ID of the lock it is blocked on |
| acq_vld | input | 1 | Lock acquire event |
| acq_lock | input | LOCK_W | Lock being acquired |
| acq_tid | input | TID_W | Thread taking the lock |
| rel_vld | input | 1 | Lock release event |
| rel_lock | input | LOCK_W | Lock being released |
| tick | input | 1 | Interval-end pulse |
| limiter_vld | output | 1 | The limiter ID is meaningful |
| limiter_tid | output | TID_W | Limiter thread ID |

## Verification
The assertions check the following on every cycle:
- the outputs only move when a search finishes;
- the limiter ID is zero whenever it is not valid;
- a search keeps running even when ticks arrive during it;
- a counter never drops except when a tick is accepted, and a saturated counter stays saturated;
- acquire and release events update the owner table.

Some properties can only be shown by the bench's scenarios, which compare against a reference model:
- which lock wins the search, including ties and saturated counts;
- that the reported owner is the one recorded at the tick edge;
- that waits in the tick cycle fall into the new interval;
- that the result appears at the exact cycle.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/cl_wait_accum.sv
module cl_wait_accum #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_LOCKS   = 8,
  parameter int CNT_W       = 20,
  parameter int LOCK_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS-1:0]       wait_vld,
  input  logic [NUM_THREADS*LOCK_W-1:0] wait_lock,
  input  logic                         clear,
  output logic [NUM_LOCKS*CNT_W-1:0]   cnt_flat
);
  localparam int INC_W = $clog2(NUM_THREADS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    logic [INC_W-1:0] inc;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] base;

    // Count the threads blocked on this lock in the current cycle.
    always_comb begin
      inc = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (wait_vld[t] && (wait_lock[t*LOCK_W +: LOCK_W] == LOCK_W'(g)))
          inc = inc + INC_W'(1);
      end
    end

    // On a clear, this cycle's waits start the new interval.
    assign base = clear ? '0 : cnt_q;
    assign sum  = {1'b0, base} + (CNT_W+1)'(inc);

    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (sum > {1'b0, CNT_MAX})
        cnt_q <= CNT_MAX;
      else
        cnt_q <= sum[CNT_W-1:0];
    end

    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/cl_holder_table.sv
module cl_holder_table #(
  parameter int NUM_LOCKS = 8,
  parameter int LOCK_W    = 3,
  parameter int TID_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acq_vld,
  input  logic [LOCK_W-1:0]          acq_lock,
  input  logic [TID_W-1:0]           acq_tid,
  input  logic                       rel_vld,
  input  logic [LOCK_W-1:0]          rel_lock,
  output logic [NUM_LOCKS-1:0]       hold_vld,
  output logic [NUM_LOCKS*TID_W-1:0] hold_tid
);
  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_entry
    logic hit_acq;
    logic hit_rel;

    assign hit_acq = acq_vld && (acq_lock == LOCK_W'(g));
    assign hit_rel = rel_vld && (rel_lock == LOCK_W'(g));

    // An acquire takes precedence over a release of the same lock.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_vld[g]                 <= 1'b0;
        hold_tid[g*TID_W +: TID_W]  <= '0;
      end else if (hit_acq) begin
        hold_vld[g]                 <= 1'b1;
        hold_tid[g*TID_W +: TID_W]  <= acq_tid;
      end else if (hit_rel) begin
        hold_vld[g]                 <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cl_max_scan.sv
module cl_max_scan
  import cl_pkg::*;
#(
  parameter int NUM_LOCKS = 8,
  parameter int CNT_W     = 20,
  parameter int LOCK_W    = 3,
  parameter int TID_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic [NUM_LOCKS*CNT_W-1:0] cnt_flat,
  input  logic [NUM_LOCKS-1:0]       hold_vld,
  input  logic [NUM_LOCKS*TID_W-1:0] hold_tid,
  output logic                       tick_acc,
  output logic                       scan_busy,
  output logic                       scan_last,
  output logic                       lim_vld,
  output logic [TID_W-1:0]           lim_tid
);
  localparam logic [LOCK_W-1:0] LAST_IDX = LOCK_W'(NUM_LOCKS - 1);

  scan_state_e state_q;
  logic [LOCK_W-1:0]          idx_q;
  logic [CNT_W-1:0]           snap_cnt [NUM_LOCKS];
  logic [NUM_LOCKS-1:0]       snap_hv;
  logic [NUM_LOCKS*TID_W-1:0] snap_ht;
  logic [LOCK_W-1:0]          best_idx_q;
  logic [CNT_W-1:0]           best_cnt_q;
  logic [LOCK_W-1:0]          cand_idx;
  logic [CNT_W-1:0]           cand_cnt;
  logic [CNT_W-1:0]           cur_cnt;

  assign scan_busy = (state_q == SCAN_RUN);
  assign tick_acc  = tick && (state_q == SCAN_IDLE);
  assign scan_last = scan_busy && (idx_q == LAST_IDX);
  assign cur_cnt   = snap_cnt[idx_q];

  // Only a strictly larger count takes over, so ties keep the lower index.
  always_comb begin
    if (cur_cnt > best_cnt_q) begin
      cand_idx = idx_q;
      cand_cnt = cur_cnt;
    end else begin
      cand_idx = best_idx_q;
      cand_cnt = best_cnt_q;
    end
  end

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rst_n)
        snap_cnt[g] <= '0;
      else if (tick_acc)
        snap_cnt[g] <= cnt_flat[g*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SCAN_IDLE;
      idx_q      <= '0;
      snap_hv    <= '0;
      snap_ht    <= '0;
      best_idx_q <= '0;
      best_cnt_q <= '0;
      lim_vld    <= 1'b0;
      lim_tid    <= '0;
    end else if (state_q == SCAN_IDLE) begin
      if (tick) begin
        // Entry 0 seeds the search; the following cycles visit entries 1 and up.
        state_q    <= SCAN_RUN;
        idx_q      <= LOCK_W'(1);
        snap_hv    <= hold_vld;
        snap_ht    <= hold_tid;
        best_idx_q <= '0;
        best_cnt_q <= cnt_flat[CNT_W-1:0];
      end
    end else begin
      best_idx_q <= cand_idx;
      best_cnt_q <= cand_cnt;
      idx_q      <= idx_q + LOCK_W'(1);
      if (idx_q == LAST_IDX) begin
        state_q <= SCAN_IDLE;
        if (snap_hv[cand_idx] && (cand_cnt != '0)) begin
          lim_vld <= 1'b1;
          lim_tid <= snap_ht[cand_idx*TID_W +: TID_W];
        end else begin
          lim_vld <= 1'b0;
          lim_tid <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/contention_limiter.sv
module contention_limiter #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_LOCKS   = 8,
  parameter int CNT_W       = 20,
  parameter int LOCK_W      = $clog2(NUM_LOCKS),
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        wait_vld,
  input  logic [NUM_THREADS*LOCK_W-1:0] wait_lock,
  input  logic                          acq_vld,
  input  logic [LOCK_W-1:0]             acq_lock,
  input  logic [TID_W-1:0]              acq_tid,
  input  logic                          rel_vld,
  input  logic [LOCK_W-1:0]             rel_lock,
  input  logic                          tick,
  output logic                          limiter_vld,
  output logic [TID_W-1:0]              limiter_tid
);
  logic                       tick_acc;
  logic                       scan_busy;
  logic                       scan_last;
  logic [NUM_LOCKS*CNT_W-1:0] cnt_flat;
  logic [NUM_LOCKS-1:0]       hold_vld;
  logic [NUM_LOCKS*TID_W-1:0] hold_tid;

  cl_wait_accum #(
    .NUM_THREADS(NUM_THREADS), .NUM_LOCKS(NUM_LOCKS),
    .CNT_W(CNT_W), .LOCK_W(LOCK_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .wait_vld(wait_vld), .wait_lock(wait_lock),
    .clear(tick_acc), .cnt_flat(cnt_flat)
  );

  cl_holder_table #(
    .NUM_LOCKS(NUM_LOCKS), .LOCK_W(LOCK_W), .TID_W(TID_W)
  ) u_holders (
    .clk(clk), .rst_n(rst_n), .acq_vld(acq_vld), .acq_lock(acq_lock),
    .acq_tid(acq_tid), .rel_vld(rel_vld), .rel_lock(rel_lock),
    .hold_vld(hold_vld), .hold_tid(hold_tid)
  );

  cl_max_scan #(
    .NUM_LOCKS(NUM_LOCKS), .CNT_W(CNT_W), .LOCK_W(LOCK_W), .TID_W(TID_W)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_flat(cnt_flat),
    .hold_vld(hold_vld), .hold_tid(hold_tid), .tick_acc(tick_acc),
    .scan_busy(scan_busy), .scan_last(scan_last),
    .lim_vld(limiter_vld), .lim_tid(limiter_tid)
  );
endmodule

// File: rtl/cl_checker.sv
module cl_checker #(
  parameter int NUM_LOCKS = 8,
  parameter int CNT_W     = 20,
  parameter int LOCK_W    = 3,
  parameter int TID_W     = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick_acc,
  input logic                       scan_busy,
  input logic                       scan_last,
  input logic [NUM_LOCKS*CNT_W-1:0] cnt_flat,
  input logic [NUM_LOCKS-1:0]       hold_vld,
  input logic                       acq_vld,
  input logic [LOCK_W-1:0]          acq_lock,
  input logic                       rel_vld,
  input logic [LOCK_W-1:0]          rel_lock,
  input logic                       limiter_vld,
  input logic [TID_W-1:0]           limiter_tid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_last |=> ($stable(limiter_vld) && $stable(limiter_tid)));

  assert_tid_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !limiter_vld |-> (limiter_tid == '0));

  assert_scan_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_busy && !scan_last) |=> scan_busy);

  assert_acquire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acq_vld |=> hold_vld[$past(acq_lock)]);

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && !(acq_vld && (acq_lock == rel_lock))) |=> !hold_vld[$past(rel_lock)]);

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_cnt
    assert_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_acc |=> (cnt_flat[g*CNT_W +: CNT_W] >= $past(cnt_flat[g*CNT_W +: CNT_W])));

    assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_flat[g*CNT_W +: CNT_W] == CNT_MAX) && !tick_acc)
      |=> (cnt_flat[g*CNT_W +: CNT_W] == CNT_MAX));
  end
endmodule

bind contention_limiter cl_checker #(
  .NUM_LOCKS(NUM_LOCKS), .CNT_W(CNT_W), .LOCK_W(LOCK_W), .TID_W(TID_W)
) u_cl_checker (.*);

// File: tb/tb_contention_limiter.sv
module tb_contention_limiter;
  localparam int NT  = 8;
  localparam int NL  = 8;
  localparam int CW  = 12;
  localparam int LW  = 3;
  localparam int TW  = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0]    wait_vld = '0;
  logic [NT*LW-1:0] wait_lock = '0;
  logic             acq_vld = 1'b0;
  logic [LW-1:0]    acq_lock = '0;
  logic [TW-1:0]    acq_tid = '0;
  logic             rel_vld = 1'b0;
  logic [LW-1:0]    rel_lock = '0;
  logic             tick = 1'b0;
  logic             limiter_vld;
  logic [TW-1:0]    limiter_tid;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  // Reference model state
  int m_cnt [NL];
  int m_hv  [NL];
  int m_ht  [NL];
  int m_cd;
  int m_vld, m_tid, p_vld, p_tid;

  always #2 clk = ~clk;

  contention_limiter #(.NUM_THREADS(NT), .NUM_LOCKS(NL), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wait_vld(wait_vld), .wait_lock(wait_lock),
    .acq_vld(acq_vld), .acq_lock(acq_lock), .acq_tid(acq_tid),
    .rel_vld(rel_vld), .rel_lock(rel_lock), .tick(tick),
    .limiter_vld(limiter_vld), .limiter_tid(limiter_tid)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) begin m_cnt[l] = 0; m_hv[l] = 0; m_ht[l] = 0; end
      m_cd = 0; m_vld = 0; m_tid = 0; p_vld = 0; p_tid = 0;
    end else begin
      automatic bit busy0 = (m_cd != 0);
      automatic bit accept = !busy0 && tick;
      if (busy0) begin
        m_cd = m_cd - 1;
        if (m_cd == 0) begin m_vld = p_vld; m_tid = p_tid; end
      end
      if (accept) begin
        automatic int best = 0;
        for (int l = 1; l < NL; l++) if (m_cnt[l] > m_cnt[best]) best = l;
        if (m_cnt[best] != 0 && m_hv[best] != 0) begin p_vld = 1; p_tid = m_ht[best]; end
        else begin p_vld = 0; p_tid = 0; end
        m_cd = NL - 1;
      end
      for (int l = 0; l < NL; l++) begin
        automatic int add = 0;
        automatic int nv;
        for (int t = 0; t < NT; t++)
          if (wait_vld[t] && int'(wait_lock[t*LW +: LW]) == l) add++;
        nv = (accept ? 0 : m_cnt[l]) + add;
        m_cnt[l] = (nv > MAXC) ? MAXC : nv;
      end
      for (int l = 0; l < NL; l++) begin
        if (acq_vld && int'(acq_lock) == l) begin m_hv[l] = 1; m_ht[l] = int'(acq_tid); end
        else if (rel_vld && int'(rel_lock) == l) m_hv[l] = 0;
      end
    end
  end

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(limiter_vld) != m_vld || int'(limiter_tid) != m_tid) begin
        failures++;
        $display("FAIL %s model: vld=%0d tid=%0d expected vld=%0d tid=%0d",
                 cur_req, limiter_vld, limiter_tid, m_vld, m_tid);
      end
    end
  end

  task automatic expect_out(string req, int ev, int et);
    checks++;
    if (int'(limiter_vld) != ev || int'(limiter_tid) != et) begin
      failures++;
      $display("FAIL %s: vld=%0d tid=%0d expected vld=%0d tid=%0d",
               req, limiter_vld, limiter_tid, ev, et);
    end
  endtask

  task automatic set_wait(int t, int l);
    wait_vld[t] = 1'b1;
    wait_lock[t*LW +: LW] = LW'(l);
  endtask

  task automatic clr_waits();
    wait_vld = '0;
  endtask

  task automatic acquire(int l, int t);
    acq_vld = 1'b1; acq_lock = LW'(l); acq_tid = TW'(t);
    @(negedge clk);
    acq_vld = 1'b0;
  endtask

  task automatic release_lk(int l);
    rel_vld = 1'b1; rel_lock = LW'(l);
    @(negedge clk);
    rel_vld = 1'b0;
  endtask

  // Pulse the tick, then wait until the result edge has passed.
  task automatic tick_and_wait();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic run_waits(int n);
    repeat (n) @(negedge clk);
    clr_waits();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    expect_out("R1 reset", 0, 0);

    // R5 / R11: winner owned by thread 5
    cur_req = "R5";
    acquire(3, 5);
    acquire(1, 2);
    set_wait(0, 3); set_wait(1, 3); set_wait(2, 1);
    run_waits(10);
    tick_and_wait();
    expect_out("R5 owner of busiest lock", 1, 5);

    // R2: three waiters for 4 cycles beat one waiter for 11 cycles
    cur_req = "R2";
    acquire(6, 1);
    acquire(2, 7);
    set_wait(4, 2);
    repeat (7) @(negedge clk);
    set_wait(0, 6); set_wait(1, 6); set_wait(3, 6);
    run_waits(4);
    tick_and_wait();
    expect_out("R2 summed waiters", 1, 1);

    // R6: busiest lock released before the tick
    cur_req = "R6";
    set_wait(5, 6); set_wait(6, 6);
    run_waits(6);
    release_lk(6);
    tick_and_wait();
    expect_out("R6 no owner", 0, 0);

    // R7: an interval with no waits
    cur_req = "R7";
    acquire(0, 4);
    repeat (3) @(negedge clk);
    tick_and_wait();
    expect_out("R7 all zero", 0, 0);

    // R4: tie between lock 4 and lock 2 goes to lock 2
    cur_req = "R4";
    acquire(4, 4);
    acquire(2, 6);
    set_wait(0, 4); set_wait(1, 2);
    run_waits(9);
    tick_and_wait();
    expect_out("R4 tie to lower index", 1, 6);

    // R8: exact result cycle
    cur_req = "R8";
    acquire(5, 3);
    set_wait(2, 5);
    run_waits(5);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (6) @(negedge clk);
    expect_out("R8 before result edge", 1, 6);
    @(negedge clk);
    expect_out("R8 at result edge", 1, 3);

    // R9: a second tick during the search is dropped; waits keep counting
    cur_req = "R9";
    set_wait(0, 1);
    run_waits(3);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    set_wait(1, 7); set_wait(2, 7); set_wait(3, 7);
    @(negedge clk);
    tick = 1'b0;
    repeat (4) @(negedge clk);
    expect_out("R9 first result", 1, 2);
    run_waits(2);
    acquire(7, 0);
    tick_and_wait();
    expect_out("R9 counts survived dropped tick", 1, 0);

    // R10: waits in the tick cycle belong to the next interval
    cur_req = "R10";
    acquire(7, 3);
    set_wait(0, 2);
    run_waits(2);
    for (int t = 0; t < NT; t++) set_wait(t, 7);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    clr_waits();
    repeat (7) @(negedge clk);
    expect_out("R10 old interval", 1, 6);
    tick_and_wait();
    expect_out("R10 tick-cycle waits carried", 1, 3);

    // R11: acquire and release of the same lock in one cycle
    cur_req = "R11";
    acq_vld = 1'b1; acq_lock = 3'd4; acq_tid = 3'd7;
    rel_vld = 1'b1; rel_lock = 3'd4;
    @(negedge clk);
    acq_vld = 1'b0; rel_vld = 1'b0;
    set_wait(3, 4);
    run_waits(4);
    tick_and_wait();
    expect_out("R11 acquire wins", 1, 7);

    // R3: saturated count ties with an exact 4095, lower index wins
    cur_req = "R3";
    acquire(1, 2);
    acquire(3, 4);
    set_wait(0, 1);
    for (int t = 1; t < NT; t++) set_wait(t, 3);
    repeat (600) @(negedge clk);
    for (int t = 1; t < NT; t++) wait_vld[t] = 1'b0;
    repeat (MAXC - 600) @(negedge clk);
    clr_waits();
    tick_and_wait();
    expect_out("R3 saturation tie", 1, 2);

    repeat (4) @(negedge clk);
    report();
  end
endmodule